// File: doc/BRIEF.md
# Serial Port Frame Sync Divider

This block produces the periodic frame sync for a serial port by counting serial clock ticks against a programmable divisor. The ticks arrive as a single-cycle enable strobe in the system clock domain. The strobe may come from an internally generated serial clock or an externally generated one. A divisor of D gives one frame sync pulse every D+1 ticks. A divisor of zero instead holds the frame sync high for as long as the port is enabled.

The same counter also serves when no serial transfer is in use. With the standalone mode selected, it works as a clock divider or a periodic pulse source and raises a one-cycle interrupt strobe on each terminal count. A configuration check compares the divisor with the word-length field, which holds the word length minus one. It flags any nonzero divisor too short to fit a word.

Top module: `frame_sync_divider`

## Requirements
- R1: While enabled with a latched divisor D > 0, `fsync` goes high on every (D+1)-th tick and stays high until the next tick. It becomes visible one clock after the tick cycle.
- R2: The clock after `port_en` rises, the counter loads the divisor. The first `fsync` pulse follows the (D+1)-th tick after that load.
- R3: With a latched divisor of zero, `fsync` is high from the clock after `port_en` rises and stays high while the port is enabled.
- R4: `cfg_err` is high one clock after a cycle in which `port_en` is high and the divisor is nonzero and numerically less than `word_len`. In every other case it is low one clock later.
- R5: The counter advances only on cycles with `sclk_tick` high. Without a tick, `fsync` holds its value while the port stays enabled.
- R6: While `port_en` is low, `fsync` and `irq` are low one clock later and ticks are ignored. Raising `port_en` again restarts the count from a fresh load.
- R7: A divisor change while counting does not shorten the current period. The new value is sampled only at the next terminal-count reload.
- R8: When `standalone` is 1, `irq` is high for exactly the one clock after each terminal-count tick. When `standalone` is 0, `irq` stays low.
- R9: A synchronous high `rst` clears the counter, `fsync`, `irq` and `cfg_err` by the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| port_en | input | 1 | Port enable; the counter runs only while high |
| sclk_tick | input | 1 | One-cycle strobe per serial clock period |
| standalone | input | 1 | 1 selects standalone pulse/interrupt mode, 0 selects frame sync use |
| divisor | input | DIV_W | Frame sync divisor (period is divisor+1 ticks) |
| word_len | input | LEN_W | Serial word length minus one |
| fsync | output | 1 | Frame sync, active high |
| irq | output | 1 | Periodic interrupt strobe in standalone mode |
| cfg_err | output | 1 | Divisor shorter than word length |

## Verification
Every output is registered. `fsync` and `irq` respond in the clock that follows the tick cycle, and `cfg_err` and the load at enable follow their input by one clock. The bench drives each input on a falling edge and samples the outputs on the next falling edge, so each tick is judged exactly one register stage later. It then waits one further idle clock. At that point it confirms that `irq` has fallen and that `fsync` has held its value. Expected pulse positions are worked out per tick index as multiples of divisor+1, counted from the enable load.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    typedef enum logic {
        FSD_MODE_PORT       = 1'b0,
        FSD_MODE_STANDALONE = 1'b1
    } fsd_mode_e;

endpackage

// File: rtl/fsd_counter.sv
module fsd_counter #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_en,
    input  logic             sclk_tick,
    input  logic [DIV_W-1:0] divisor,
    output logic             fsync,
    output logic             term_evt
);

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] cnt;
        logic             fs;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       evt_d;

    always_comb begin
        st_d  = st_q;
        evt_d = 1'b0;
        if (!port_en) begin
            st_d = '0;
        end else if (!st_q.run) begin
            // first enabled cycle: load the period
            st_d.run = 1'b1;
            st_d.cnt = divisor;
            st_d.fs  = (divisor == '0);
        end else if (sclk_tick) begin
            if (st_q.cnt == '0) begin
                evt_d    = 1'b1;
                st_d.fs  = 1'b1;
                st_d.cnt = divisor;
            end else begin
                st_d.fs  = 1'b0;
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fsync    = st_q.fs;
    assign term_evt = evt_d;

endmodule

// File: rtl/fsd_cfg_check.sv
module fsd_cfg_check #(
    parameter int DIV_W = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_en,
    input  logic [DIV_W-1:0] divisor,
    input  logic [LEN_W-1:0] word_len,
    output logic             cfg_err
);

    localparam int CMP_W = (DIV_W > LEN_W) ? DIV_W : LEN_W;

    typedef struct packed {
        logic err;
    } chk_state_t;

    chk_state_t        st_d, st_q;
    logic [CMP_W-1:0]  div_ext;
    logic [CMP_W-1:0]  len_ext;

    assign div_ext = CMP_W'(divisor);
    assign len_ext = CMP_W'(word_len);

    always_comb begin
        st_d     = st_q;
        st_d.err = port_en && (div_ext != '0) && (div_ext < len_ext);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_err = st_q.err;

endmodule

// File: rtl/fsd_irq_gen.sv
module fsd_irq_gen (
    input  logic              clk,
    input  logic              rst,
    input  logic              term_evt,
    input  fsd_pkg::fsd_mode_e mode,
    output logic              irq
);

    typedef struct packed {
        logic strobe;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = term_evt && (mode == fsd_pkg::FSD_MODE_STANDALONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.strobe;

endmodule

// File: rtl/frame_sync_divider.sv
module frame_sync_divider #(
    parameter int DIV_W = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_en,
    input  logic             sclk_tick,
    input  logic             standalone,
    input  logic [DIV_W-1:0] divisor,
    input  logic [LEN_W-1:0] word_len,
    output logic             fsync,
    output logic             irq,
    output logic             cfg_err
);

    logic               term_evt;
    fsd_pkg::fsd_mode_e mode;

    assign mode = fsd_pkg::fsd_mode_e'(standalone);

    fsd_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .port_en   (port_en),
        .sclk_tick (sclk_tick),
        .divisor   (divisor),
        .fsync     (fsync),
        .term_evt  (term_evt)
    );

    fsd_cfg_check #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_chk_cfg (
        .clk      (clk),
        .rst      (rst),
        .port_en  (port_en),
        .divisor  (divisor),
        .word_len (word_len),
        .cfg_err  (cfg_err)
    );

    fsd_irq_gen u_irq (
        .clk      (clk),
        .rst      (rst),
        .term_evt (term_evt),
        .mode     (mode),
        .irq      (irq)
    );

endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
    parameter int DIV_W = 16,
    parameter int LEN_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             port_en,
    input logic             sclk_tick,
    input logic             standalone,
    input logic [DIV_W-1:0] divisor,
    input logic [LEN_W-1:0] word_len,
    input logic             fsync,
    input logic             irq,
    input logic             cfg_err
);

    localparam int CW = (DIV_W > LEN_W) ? DIV_W : LEN_W;

    logic [CW-1:0] dv;
    logic [CW-1:0] lv;
    assign dv = CW'(divisor);
    assign lv = CW'(word_len);

    // R8: a strobe needs standalone mode, an enabled port and a tick one clock earlier
    a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(standalone) && $past(sclk_tick) && $past(port_en)));

    // R6: a disabled port is silent on the next clock
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> (!fsync && !irq));

    // R5: no tick while already running means fsync holds
    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (port_en && $past(port_en) && !$past(rst) && !sclk_tick) |=> $stable(fsync));

    // R4: error only for a short nonzero divisor seen one clock earlier
    a_r4_err_cause: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> ($past(port_en) && ($past(dv) != '0) && ($past(dv) < $past(lv))));

    // R1: a rising frame sync needs an enabled port one clock earlier
    a_r1_rise_enabled: assert property (@(posedge clk) disable iff (rst)
        $rose(fsync) |-> $past(port_en));

endmodule

bind frame_sync_divider fsd_checker #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_fsd_chk (
    .clk        (clk),
    .rst        (rst),
    .port_en    (port_en),
    .sclk_tick  (sclk_tick),
    .standalone (standalone),
    .divisor    (divisor),
    .word_len   (word_len),
    .fsync      (fsync),
    .irq        (irq),
    .cfg_err    (cfg_err)
);

// File: tb/sim_frame_sync_divider.sv
`timescale 1ns/1ps
module sim_frame_sync_divider;

    localparam int DIV_W = 16;
    localparam int LEN_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             port_en = 1'b0;
    logic             sclk_tick = 1'b0;
    logic             standalone = 1'b0;
    logic [DIV_W-1:0] divisor = '0;
    logic [LEN_W-1:0] word_len = '0;
    logic             fsync, irq, cfg_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    frame_sync_divider #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .port_en(port_en), .sclk_tick(sclk_tick),
        .standalone(standalone), .divisor(divisor), .word_len(word_len),
        .fsync(fsync), .irq(irq), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [15:0] d;
        logic [4:0]  l;
        logic        sa;
        logic        err;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'd3, 5'd2, 1'b0, 1'b0},
        '{16'd5, 5'd5, 1'b1, 1'b0},
        '{16'd1, 5'd4, 1'b0, 1'b1},
        '{16'd0, 5'd7, 1'b1, 1'b0},
        '{16'd7, 5'd3, 1'b1, 1'b0},
        '{16'd2, 5'd2, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // one tick; returns outputs sampled one clock later
    task automatic tick(output logic fs, output logic iq);
        @(negedge clk) sclk_tick = 1'b1;
        @(negedge clk) sclk_tick = 1'b0;
        fs = fsync;
        iq = irq;
    endtask

    task automatic enable_port();
        @(negedge clk) port_en = 1'b1;
        @(negedge clk);
    endtask

    // run ticks 1..n and compare against pulses at multiples of per
    task automatic run_ticks(input int first, input int n, input int per,
                             input bit sa, input string req);
        logic fs, iq, fs_hold;
        for (int k = first; k < first + n; k++) begin
            bit exp_fs;
            exp_fs = ((k % per) == 0);
            tick(fs, iq);
            chk(fs == exp_fs, req, fs, exp_fs);
            chk(iq == (exp_fs && sa), "R8", iq, exp_fs && sa);
            fs_hold = fs;
            @(negedge clk);
            chk(fsync == fs_hold, "R5", fsync, fs_hold);
            chk(irq == 1'b0, "R8", irq, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        logic fs, iq;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(fsync == 1'b0 && irq == 1'b0 && cfg_err == 1'b0, "R9", {fsync, irq, cfg_err}, 0);
        @(negedge clk) rst = 1'b0;

        // table walk: R1 R2 R3 R4 R8
        for (int v = 0; v < NV; v++) begin
            @(negedge clk) port_en = 1'b0;
            divisor    = VECS[v].d;
            word_len   = VECS[v].l;
            standalone = VECS[v].sa;
            @(negedge clk);
            enable_port();
            chk(cfg_err == VECS[v].err, "R4", cfg_err, VECS[v].err);
            if (VECS[v].d == 0) begin
                chk(fsync == 1'b1, "R3", fsync, 1);
                run_ticks(1, 4, 1, VECS[v].sa, "R3");
            end else begin
                chk(fsync == 1'b0, "R2", fsync, 0);
                run_ticks(1, 3 * (int'(VECS[v].d) + 1), int'(VECS[v].d) + 1,
                          VECS[v].sa, "R1");
            end
        end

        // R6: disabled port ignores ticks
        @(negedge clk) port_en = 1'b0;
        divisor = '0; standalone = 1'b1; word_len = 5'd0;
        for (int k = 0; k < 4; k++) begin
            tick(fs, iq);
            chk(fs == 1'b0 && iq == 1'b0, "R6", {fs, iq}, 0);
        end

        // R6: disable mid-count, re-enable restarts the period (R2)
        divisor = 16'd2; standalone = 1'b0;
        enable_port();
        tick(fs, iq);
        tick(fs, iq);
        @(negedge clk) port_en = 1'b0;
        @(negedge clk);
        chk(fsync == 1'b0, "R6", fsync, 0);
        enable_port();
        run_ticks(1, 6, 3, 1'b0, "R2");

        // R7: divisor changed mid-period; pulse at 5, then every 2
        @(negedge clk) port_en = 1'b0;
        divisor = 16'd4; standalone = 1'b1;
        @(negedge clk);
        enable_port();
        run_ticks(1, 2, 5, 1'b1, "R7");
        divisor = 16'd1;
        run_ticks(3, 3, 5, 1'b1, "R7");
        tick(fs, iq);
        chk(fs == 1'b0, "R7", fs, 0);
        tick(fs, iq);
        chk(fs == 1'b1, "R7", fs, 1);
        tick(fs, iq);
        chk(fs == 1'b0, "R7", fs, 0);
        tick(fs, iq);
        chk(fs == 1'b1 && iq == 1'b1, "R7", {fs, iq}, 3);

        // R4 boundary: divisor equal to word_len is legal, one less is not
        @(negedge clk) word_len = 5'd9; divisor = 16'd9;
        @(negedge clk);
        chk(cfg_err == 1'b0, "R4", cfg_err, 0);
        @(negedge clk) divisor = 16'd8;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R4", cfg_err, 1);
        @(negedge clk) port_en = 1'b0;
        @(negedge clk);
        chk(cfg_err == 1'b0, "R4", cfg_err, 0);

        // R9: reset mid-run clears everything
        @(negedge clk) divisor = 16'd1; word_len = 5'd4; standalone = 1'b1;
        enable_port();
        tick(fs, iq);
        tick(fs, iq);
        chk(fs == 1'b1 && cfg_err == 1'b1, "R9", {fs, cfg_err}, 3);
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        chk(fsync == 1'b0 && irq == 1'b0 && cfg_err == 1'b0, "R9",
            {fsync, irq, cfg_err}, 0);
        @(negedge clk) rst = 1'b0; port_en = 1'b0;
        @(negedge clk);

        done = 1'b1;
        report();
        $finish;
    end

endmodule